// File: doc/BRIEF.md
# Delta-Sigma ADC Serial Readout and Offset-Calibration Controller

This block runs on the host side of a 24-bit delta-sigma converter whose single output line carries both the "result ready" indication and the serial data. The block watches that line through a synchronizer. When the line drops low, it generates a serial clock from the system clock and shifts in 24 bits, most significant bit first. It then presents the two's-complement word with a one-cycle valid strobe.

Software or a neighbouring block can ask for an offset calibration with a one-cycle request. The request is held until the next read. That read issues two extra clock pulses after the data bits, 26 in total, and the converter starts its calibration on the last falling edge. The converter drives the line high during pulse 25, and that level is never taken as data. While the converter calibrates, the serial clock stays low. The block then waits for the line to fall again and reads the first settled result straight away. A speed input selects the expected settling time. If the line stays high for that time plus a 5% margin, a timeout flag is raised.

The serial clock high and low phases each last `max(SCLK_HALF, MIN_HALF)` system cycles. Because the data line passes through a two-stage synchronizer, the half period must be at least three cycles.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset, `sclk` is low and `smp_valid`, `cal_busy` and `cal_timeout` are all 0.
- R2: While the data line stays high and no read is in progress, `sclk` produces no pulses.
- R3: A read without calibration produces exactly 24 `sclk` pulses. Each high phase lasts exactly max(SCLK_HALF, MIN_HALF) system cycles.
- R4: Bits are sampled at the falling edge of `sclk`, first bit into `smp_data[23]`. After the 24th falling edge, `smp_valid` is high for exactly one cycle, and `smp_data` then holds the received word.
- R5: A pulse on `cal_req` outside calibration is held, and the next read issues 26 `sclk` pulses. That read raises no `smp_valid`.
- R6: `cal_busy` rises after the 26th falling edge. It stays high with `sclk` held low until the line goes low or the timeout expires.
- R7: When the line falls during calibration, the block starts a normal 24-pulse read at once and delivers that result with `smp_valid`.
- R8: If the line stays high for CYC + CYC/20 cycles of calibration, `cal_timeout` goes to 1 and `cal_busy` drops. The flag is cleared when the next calibration starts.
- R9: A `cal_req` pulse while `cal_busy` is high is ignored. The following reads each issue 24 pulses.
- R10: A `cal_req` pulse during a normal read is held and applied to the next read (26 pulses).
- R11: After a normal read, no new read starts until the line has been seen high again, even if the line is left low.
- R12: `speed`=1 selects the fast calibration time (CAL_FAST_CYC) and `speed`=0 the slow one (CAL_SLOW_CYC). The value is captured when calibration starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_line | input | 1 | Shared ready/data line from the converter |
| speed | input | 1 | 1 = fast conversion rate, 0 = slow |
| cal_req | input | 1 | One-cycle offset-calibration request |
| sclk | output | 1 | Generated serial clock to the converter |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| smp_data | output | 24 | Received sample, two's complement |
| cal_busy | output | 1 | Calibration wait in progress |
| cal_timeout | output | 1 | Calibration wait expired without completion |

## Verification
Random 24-bit words with both polarities of the last bit exercise the bit order and show whether a stale low line after a read re-triggers. Randomly placed calibration requests, with random completion delays, show whether the 26-pulse count, the suppression of the extra bit and the immediate post-calibration read interact correctly. Directed cases place requests during a read and during calibration, which shows latching apart from ignoring. They also hold the line high past the fast limit under both speed settings, which shows the timeout apart from a legitimate slow settle.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_REARM = 2'd2,
    ST_CAL   = 2'd3
  } rd_state_t;
endpackage

// File: rtl/adc_rd_sclk_gen.sv
// Serial clock divider: equal high/low phases of HALF cycles while run is set.
module adc_rd_sclk_gen #(
  parameter int HALF      = 4,
  parameter bit SMP_FALL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic fall_evt,
  output logic samp_evt
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] hcnt_q, hcnt_n;
  logic          sclk_n;
  logic          wrap;

  assign wrap     = (hcnt_q == CW'(HALF - 1));
  assign fall_evt = run & sclk & wrap;
  assign samp_evt = run & wrap & (sclk == SMP_FALL);

  always_comb begin
    hcnt_n = hcnt_q;
    sclk_n = sclk;
    if (!run) begin
      hcnt_n = '0;
      sclk_n = 1'b0;
    end else if (wrap) begin
      hcnt_n = '0;
      sclk_n = ~sclk;
    end else begin
      hcnt_n = hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      sclk   <= 1'b0;
    end else begin
      hcnt_q <= hcnt_n;
      sclk   <= sclk_n;
    end
  end
endmodule

// File: rtl/adc_rd_shifter.sv
// MSB-first input shift register.
module adc_rd_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  logic [W-1:0] word_n;

  always_comb begin
    word_n = word;
    if (shift_en) word_n = {word[W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else        word <= word_n;
  end
endmodule

// File: rtl/adc_rd_cal_timer.sv
// Calibration watchdog: limit is the nominal time plus 5 percent.
module adc_rd_cal_timer #(
  parameter int FAST_CYC = 25_320_000,
  parameter int SLOW_CYC = 200_255_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fast,
  input  logic run,
  output logic expired
);
  localparam int FAST_LIM = FAST_CYC + FAST_CYC / 20;
  localparam int SLOW_LIM = SLOW_CYC + SLOW_CYC / 20;
  localparam int MAX_LIM  = (FAST_LIM > SLOW_LIM) ? FAST_LIM : SLOW_LIM;
  localparam int CW       = $clog2(MAX_LIM + 2);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          fast_q, fast_n;
  logic [CW-1:0] lim;

  assign lim     = fast_q ? CW'(FAST_LIM) : CW'(SLOW_LIM);
  assign expired = run & (cnt_q >= lim);

  always_comb begin
    cnt_n  = cnt_q;
    fast_n = fast_q;
    if (start) begin
      cnt_n  = '0;
      fast_n = fast;
    end else if (run && !expired) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fast_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_n;
      fast_q <= fast_n;
    end
  end
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W       = 24,
  parameter int CAL_EXTRA    = 2,
  parameter int SCLK_HALF    = 4,
  parameter int MIN_HALF     = 3,
  parameter bit SMP_FALL     = 1'b1,
  parameter int SYNC_STAGES  = 2,
  parameter int CAL_FAST_CYC = 25_320_000,
  parameter int CAL_SLOW_CYC = 200_255_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_line,
  input  logic              speed,
  input  logic              cal_req,
  output logic              sclk,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic              cal_busy,
  output logic              cal_timeout
);
  localparam int EFF_HALF = (SCLK_HALF < MIN_HALF) ? MIN_HALF : SCLK_HALF;
  localparam int TOTAL    = DATA_W + CAL_EXTRA;
  localparam int PW       = $clog2(TOTAL + 1);

  // line synchronizer, idles high
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b1;
      else if (g == 0) sync_q[g] <= adc_line;
      else sync_q[g] <= sync_q[(g > 0) ? g - 1 : 0];
    end
  end
  assign line_s = sync_q[SYNC_STAGES-1];

  rd_state_t     state_q, state_n;
  logic [PW-1:0] pcnt_q, pcnt_n;
  logic          cal_cur_q, cal_cur_n;
  logic          pend_q, pend_n;
  logic          valid_q, valid_n;
  logic          tmo_q, tmo_n;
  logic          take, tmr_start, tmr_exp;
  logic          run, fall_evt, samp_evt, last_pulse, shift_en;
  logic [PW-1:0] last_idx;

  assign run      = (state_q == ST_SHIFT);
  assign last_idx = cal_cur_q ? PW'(TOTAL - 1) : PW'(DATA_W - 1);
  assign last_pulse = fall_evt && (pcnt_q == last_idx);
  assign shift_en = run && samp_evt && (pcnt_q < PW'(DATA_W));

  adc_rd_sclk_gen #(.HALF(EFF_HALF), .SMP_FALL(SMP_FALL)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(sclk), .fall_evt(fall_evt), .samp_evt(samp_evt)
  );

  adc_rd_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .bit_in(line_s), .word(smp_data)
  );

  adc_rd_cal_timer #(.FAST_CYC(CAL_FAST_CYC), .SLOW_CYC(CAL_SLOW_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .fast(speed),
    .run(state_q == ST_CAL), .expired(tmr_exp)
  );

  always_comb begin
    state_n   = state_q;
    pcnt_n    = pcnt_q;
    cal_cur_n = cal_cur_q;
    valid_n   = 1'b0;
    tmo_n     = tmo_q;
    take      = 1'b0;
    tmr_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!line_s) begin
          state_n   = ST_SHIFT;
          pcnt_n    = '0;
          cal_cur_n = pend_q;
          take      = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (fall_evt) pcnt_n = pcnt_q + 1'b1;
        if (last_pulse) begin
          if (cal_cur_q) begin
            state_n   = ST_CAL;
            tmr_start = 1'b1;
            tmo_n     = 1'b0;
          end else begin
            state_n = ST_REARM;
            valid_n = 1'b1;
          end
        end
      end
      ST_REARM: begin
        if (line_s) state_n = ST_IDLE;
      end
      ST_CAL: begin
        if (!line_s) begin
          state_n   = ST_SHIFT;
          pcnt_n    = '0;
          cal_cur_n = pend_q;
          take      = 1'b1;
        end else if (tmr_exp) begin
          state_n = ST_IDLE;
          tmo_n   = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    pend_n = (pend_q & ~take) | (cal_req & (state_q != ST_CAL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pcnt_q    <= '0;
      cal_cur_q <= 1'b0;
      pend_q    <= 1'b0;
      valid_q   <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      state_q   <= state_n;
      pcnt_q    <= pcnt_n;
      cal_cur_q <= cal_cur_n;
      pend_q    <= pend_n;
      valid_q   <= valid_n;
      tmo_q     <= tmo_n;
    end
  end

  assign smp_valid   = valid_q;
  assign cal_busy    = (state_q == ST_CAL);
  assign cal_timeout = tmo_q;
endmodule

// File: rtl/adc_readout_ctrl_chk.sv
module adc_readout_ctrl_chk #(
  parameter int SCLK_HALF = 4,
  parameter int MIN_HALF  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic smp_valid,
  input logic cal_busy,
  input logic cal_timeout
);
  localparam int HALF = (SCLK_HALF < MIN_HALF) ? MIN_HALF : SCLK_HALF;

  int hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_cnt <= 0;
    else if (sclk) hi_cnt <= hi_cnt + 1;
    else           hi_cnt <= 0;
  end

  assert_high_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_cnt == HALF));

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  assert_no_valid_cal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> !smp_valid);

  assert_sclk_idle_cal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> !sclk);

  assert_timeout_from_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_timeout) |-> ($past(cal_busy) && !cal_busy));
endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk #(
  .SCLK_HALF(SCLK_HALF), .MIN_HALF(MIN_HALF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .smp_valid(smp_valid),
  .cal_busy(cal_busy), .cal_timeout(cal_timeout)
);

// File: tb/tb_adc_readout_ctrl.sv
module tb_adc_readout_ctrl;
  localparam int HALF = 4;
  localparam int FAST = 300;
  localparam int SLOW = 900;
  localparam int FAST_LIM = FAST + FAST / 20;

  logic        clk, rst_n, adc_line, speed, cal_req;
  logic        sclk, smp_valid, cal_busy, cal_timeout;
  logic [23:0] smp_data;

  adc_readout_ctrl #(
    .SCLK_HALF(HALF), .MIN_HALF(3), .CAL_FAST_CYC(FAST), .CAL_SLOW_CYC(SLOW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .adc_line(adc_line), .speed(speed), .cal_req(cal_req),
    .sclk(sclk), .smp_valid(smp_valid), .smp_data(smp_data),
    .cal_busy(cal_busy), .cal_timeout(cal_timeout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int rise_cnt = 0, fall_cnt = 0, vcount = 0, hi_run = 0;
  int hi_min = 1000, hi_max = 0;
  logic [23:0] model_word = '0, vdata = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // converter model: next bit on rising sclk, forced high on pulse 25
  always @(posedge sclk) begin
    rise_cnt++;
    if (rise_cnt >= 1 && rise_cnt <= 24) adc_line = model_word[24 - rise_cnt];
    else if (rise_cnt == 25) adc_line = 1'b1;
  end

  always @(negedge sclk) fall_cnt++;

  always @(negedge clk) begin
    cyc++;
    if (smp_valid) begin
      vcount++;
      vdata = smp_data;
    end
    if (sclk) hi_run++;
    else if (hi_run > 0) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int exp_pulses(input bit cal);
    return cal ? 26 : 24;
  endfunction

  task automatic do_read(input logic [23:0] w, input bit cal, input string req);
    int t = 0;
    model_word = w; rise_cnt = 0; fall_cnt = 0; vcount = 0;
    adc_line = 1'b0;
    while (fall_cnt < exp_pulses(cal) && t < 3000) begin
      @(negedge clk); t++;
    end
    repeat (3 * HALF + 4) @(negedge clk);
    chk(fall_cnt == exp_pulses(cal), req, "pulse count", fall_cnt, exp_pulses(cal));
    chk(vcount == (cal ? 0 : 1), req, "valid count", vcount, cal ? 0 : 1);
    if (!cal) chk(vdata == w, req, "data", vdata, w);
  endtask

  task automatic release_line();
    adc_line = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_cal();
    @(negedge clk) cal_req = 1'b1;
    @(negedge clk) cal_req = 1'b0;
  endtask

  // wait d cycles in calibration, checking sclk idle and busy
  task automatic cal_wait(input int d, input string req);
    bit ok = 1'b1;
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      if (!cal_busy || sclk) ok = 1'b0;
    end
    chk(ok, req, "busy with sclk idle", ok, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; adc_line = 1'b1; speed = 1'b1; cal_req = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!sclk && !smp_valid && !cal_busy && !cal_timeout, "R1", "reset outputs",
        {sclk, smp_valid, cal_busy, cal_timeout}, 0);
    rst_n = 1'b1;
    // R2 no pulses while line high
    rise_cnt = 0;
    repeat (60) @(negedge clk);
    chk(rise_cnt == 0, "R2", "pulses while high", rise_cnt, 0);

    // R3/R4 directed normal read, LSB 0 for R11
    do_read(24'h800002, 1'b0, "R4");
    chk(hi_min == HALF && hi_max == HALF, "R3", "high width", hi_max, HALF);
    // R11 line stays low after read: no new read
    rise_cnt = 0;
    repeat (50) @(negedge clk);
    chk(rise_cnt == 0, "R11", "re-trigger on stale low", rise_cnt, 0);
    release_line();
    do_read(24'h7FFFFF, 1'b0, "R4");
    release_line();

    // R5/R6/R7 calibration, fast speed
    pulse_cal();
    do_read(24'h123456, 1'b1, "R5");
    chk(cal_busy == 1'b1 && cal_timeout == 1'b0, "R6", "busy after pulse 26",
        cal_busy, 1);
    cal_wait(100, "R6");
    do_read(24'hA5C3F0, 1'b0, "R7");
    chk(cal_busy == 1'b0, "R7", "busy cleared", cal_busy, 0);
    release_line();

    // R8 timeout at fast speed
    pulse_cal();
    do_read(24'h000001, 1'b1, "R8");
    repeat (FAST_LIM - 40) @(negedge clk);
    chk(cal_timeout == 1'b0 && cal_busy == 1'b1, "R8", "not yet expired", cal_timeout, 0);
    repeat (60) @(negedge clk);
    chk(cal_timeout == 1'b1 && cal_busy == 1'b0, "R8", "expired", cal_timeout, 1);
    // R8 flag cleared by next calibration start; R12 slow speed
    speed = 1'b0;
    pulse_cal();
    do_read(24'h00FF00, 1'b1, "R8");
    chk(cal_timeout == 1'b0, "R8", "flag cleared", cal_timeout, 0);
    cal_wait(600, "R12");
    chk(cal_timeout == 1'b0, "R12", "slow limit honoured", cal_timeout, 0);
    // R9 request during calibration ignored
    pulse_cal();
    do_read(24'h3C3C3C, 1'b0, "R9");
    release_line();
    do_read(24'hC3C3C2, 1'b0, "R9");
    release_line();
    speed = 1'b1;

    // R10 request during a normal read is latched
    fork
      do_read(24'h55AA54, 1'b0, "R10");
      begin repeat (60) @(negedge clk); cal_req = 1'b1; @(negedge clk); cal_req = 1'b0; end
    join
    release_line();
    do_read(24'h0F0F0F, 1'b1, "R10");
    cal_wait(50, "R10");
    do_read(24'hF0F0F0, 1'b0, "R7");
    release_line();

    // constrained random reads with occasional calibration
    for (int k = 0; k < 20; k++) begin
      logic [23:0] w;
      w = 24'($urandom);
      if ($urandom % 4 == 0) begin
        pulse_cal();
        do_read(w, 1'b1, "R5");
        cal_wait(20 + int'($urandom % 180), "R6");
        w = 24'($urandom);
        do_read(w, 1'b0, "R7");
      end else begin
        do_read(w, 1'b0, "R4");
      end
      release_line();
    end
    chk(hi_min == HALF && hi_max == HALF, "R3", "high width overall", hi_min, HALF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule